// File: doc/BRIEF.md
# I2C Master SCL Generator with Clock-Stretch Wait

This block produces the SCL clock for an I2C master. A reloadable down-counter sets the length of every low and high half-period of SCL. The block drives SCL only through an open-drain enable: a high enable pulls the line low, and a low enable lets the line float. When the block lets SCL float, it waits until the synchronized line actually reads high. Only then does it reload the counter and time the high phase. A slave that stretches the clock therefore lengthens the low time, but never shortens the high time that follows.

The counter advances on two evenly spaced phases of an internal four-phase cycle. That is one decrement every second system clock. Software issues single-cycle requests for start, repeated start, stop, transmit or receive. Each request expands into a fixed pattern of half-periods. Requests are accepted only while the block is idle, and none are queued. A data-buffer write that arrives while a sequence runs is refused and raises a sticky collision flag.

Top module: `i2c_scl_gen`

## Requirements
- R1: After reset, scl_oe_o, busy_o and wcol_o are 0 and buf_o is 0.
- R2: A free-running phase counter cycles 0,1,2,3. The baud counter decrements by one only on phases 1 and 3, and only while it is nonzero. A driven-low half-period with reload N therefore lasts 2N or 2N+1 clocks.
- R3: A low half-period drives scl_oe_o=1, loads the counter from reload_i, and ends in the cycle after the counter reads zero. With reload 0 it ends one clock later.
- R4: While SCL is released (scl_oe_o=0) and the synchronized line still reads low, the counter is frozen, busy_o stays 1 and the sequence does not advance, for any length of time.
- R5: scl_i passes through a two-flop synchronizer. On the first clock where the synchronized value is 1 during a released phase, the counter loads from reload_i and the high phase is timed from there. A high phase with reload N keeps the line high for at least 2N clocks.
- R6: Sequences, given as half-periods (L = driven low, H = released):
  - start: H, then SCL is left driven low.
  - repeated start: L H, then SCL is left driven low.
  - stop: L H, then SCL is left released.
  - transmit and receive: 18 half-periods alternating L H, then SCL is left driven low.
- R7: If several requests are raised in the same idle cycle, only one is taken, in this priority: start, repeated start, stop, transmit, receive.
- R8: A request raised while busy_o=1 is ignored. It is not remembered for later.
- R9: A buffer write while busy_o=0 loads buf_o from buf_wdata_i on the next edge. A buffer write while busy_o=1 leaves buf_o unchanged and sets wcol_o.
- R10: wcol_o stays 1 until wcol_clr_i is pulsed. If a collision and a clear occur in the same cycle, the flag ends up set.
- R11: busy_o rises on the edge that accepts a request and falls when the last half-period ends with the counter at zero. While busy_o=0 the counter stays at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reload_i | input | RELOAD_W | Counter reload value for each half-period |
| scl_i | input | 1 | Raw SCL line level, asynchronous |
| start_req_i | input | 1 | Start sequence request pulse |
| rstart_req_i | input | 1 | Repeated start request pulse |
| stop_req_i | input | 1 | Stop sequence request pulse |
| tx_req_i | input | 1 | Transmit byte clocking request pulse |
| rx_req_i | input | 1 | Receive byte clocking request pulse |
| buf_wr_i | input | 1 | Data buffer write strobe |
| buf_wdata_i | input | DATA_W | Data for a buffer write |
| wcol_clr_i | input | 1 | Clears the write-collision flag |
| scl_oe_o | output | 1 | Open-drain enable, 1 pulls SCL low |
| busy_o | output | 1 | A sequence is in progress |
| wcol_o | output | 1 | Sticky write-collision flag |
| buf_o | output | DATA_W | Data buffer contents |

## Verification
Two functions can meet in one cycle. A refused buffer write sets the collision flag, and software may clear that flag in the same cycle. The bench raises the write strobe and the clear strobe together in the middle of a running sequence, and expects the flag to be set afterwards. A request being accepted can also coincide with a buffer write in the last idle cycle, and with other requests. The bench raises start and stop together from idle and checks that the line stays released, as a start requires. Every clock, the outputs are compared with a behavioural model that predicts each edge from the same inputs.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOW   = 2'd1,
    ST_HWAIT = 2'd2,
    ST_HCNT  = 2'd3
  } scl_state_e;
endpackage

// File: rtl/i2c_phase_gen.sv
module i2c_phase_gen #(
  parameter int PHASES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int PH_W = $clog2(PHASES);

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          ph_q <= '0;
    else if (ph_q == PH_W'(PHASES - 1))   ph_q <= '0;
    else                                  ph_q <= ph_q + PH_W'(1);
  end

  // R2: decrement enable on odd phases
  assign tick_o = ph_q[0];
endmodule

// File: rtl/i2c_sync.sv
module i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;  // idle bus reads high
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/i2c_brg.sv
module i2c_brg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] reload_i,
  input  logic         run_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                cnt_q <= '0;
    else if (load_i)                            cnt_q <= reload_i;
    else if (run_i && tick_i && cnt_q != '0)    cnt_q <= cnt_q - W'(1);
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen
  import i2c_scl_pkg::*;
#(
  parameter int RELOAD_W    = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int PHASES      = 4,
  parameter int XFER_BITS   = 9
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [RELOAD_W-1:0] reload_i,
  input  logic                scl_i,
  input  logic                start_req_i,
  input  logic                rstart_req_i,
  input  logic                stop_req_i,
  input  logic                tx_req_i,
  input  logic                rx_req_i,
  input  logic                buf_wr_i,
  input  logic [DATA_W-1:0]   buf_wdata_i,
  input  logic                wcol_clr_i,
  output logic                scl_oe_o,
  output logic                busy_o,
  output logic                wcol_o,
  output logic [DATA_W-1:0]   buf_o
);
  localparam int HALVES = 2 * XFER_BITS;
  localparam int LEFT_W = $clog2(HALVES);

  scl_state_e          st_q, st_d;
  logic [LEFT_W-1:0]   left_q, left_d;
  logic                endlow_q, endlow_d;
  logic                oe_q, oe_d;
  logic [RELOAD_W-1:0] cnt;
  logic                cnt_zero, load, run, tick, scl_s;
  logic                req_any, req_first_low, req_end_low;
  logic [LEFT_W-1:0]   req_left;
  logic                wcol_q;
  logic [DATA_W-1:0]   buf_q;

  i2c_phase_gen #(.PHASES(PHASES)) u_phase (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (scl_i),
    .q_o   (scl_s)
  );

  i2c_brg #(.W(RELOAD_W)) u_brg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .reload_i(reload_i),
    .run_i   (run),
    .tick_i  (tick),
    .cnt_o   (cnt),
    .zero_o  (cnt_zero)
  );

  // R7: fixed priority request decode
  always_comb begin
    req_any       = start_req_i | rstart_req_i | stop_req_i | tx_req_i | rx_req_i;
    req_first_low = 1'b1;
    req_end_low   = 1'b1;
    req_left      = LEFT_W'(HALVES - 1);
    if (start_req_i) begin
      req_first_low = 1'b0;
      req_left      = '0;
    end else if (rstart_req_i) begin
      req_left      = LEFT_W'(1);
    end else if (stop_req_i) begin
      req_left      = LEFT_W'(1);
      req_end_low   = 1'b0;
    end
  end

  always_comb begin
    st_d     = st_q;
    left_d   = left_q;
    endlow_d = endlow_q;
    oe_d     = oe_q;
    load     = 1'b0;
    run      = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_any) begin
          left_d   = req_left;
          endlow_d = req_end_low;
          if (req_first_low) begin
            st_d = ST_LOW;
            oe_d = 1'b1;
            load = 1'b1;
          end else begin
            st_d = ST_HWAIT;
            oe_d = 1'b0;
          end
        end
      end
      ST_HWAIT: begin
        // R4/R5: frozen until the line is seen high
        if (scl_s) begin
          load = 1'b1;
          st_d = ST_HCNT;
        end
      end
      default: begin  // ST_LOW, ST_HCNT
        run = 1'b1;
        if (cnt_zero) begin
          if (left_q == '0) begin
            st_d = ST_IDLE;
            oe_d = endlow_q;
          end else begin
            left_d = left_q - LEFT_W'(1);
            if (st_q == ST_LOW) begin
              st_d = ST_HWAIT;
              oe_d = 1'b0;
            end else begin
              st_d = ST_LOW;
              oe_d = 1'b1;
              load = 1'b1;
            end
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      left_q   <= '0;
      endlow_q <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      st_q     <= st_d;
      left_q   <= left_d;
      endlow_q <= endlow_d;
      oe_q     <= oe_d;
    end
  end

  // R9/R10: buffer guard, collision set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      wcol_q <= 1'b0;
    end else begin
      if (buf_wr_i && busy_o)  wcol_q <= 1'b1;
      else if (wcol_clr_i)     wcol_q <= 1'b0;
      if (buf_wr_i && !busy_o) buf_q  <= buf_wdata_i;
    end
  end

  assign busy_o   = (st_q != ST_IDLE);
  assign scl_oe_o = oe_q;
  assign wcol_o   = wcol_q;
  assign buf_o    = buf_q;
endmodule

// File: rtl/i2c_scl_gen_chk.sv
module i2c_scl_gen_chk
  import i2c_scl_pkg::*;
#(
  parameter int W      = 8,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input scl_state_e        st_q,
  input logic [W-1:0]      cnt,
  input logic              scl_s,
  input logic [W-1:0]      reload_i,
  input logic              buf_wr_i,
  input logic              wcol_clr_i,
  input logic              busy_o,
  input logic              wcol_o,
  input logic [DATA_W-1:0] buf_o,
  input logic              scl_oe_o
);
  a_r4_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HWAIT && !scl_s) |=> ($stable(cnt) && st_q == ST_HWAIT && busy_o));

  a_r4_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HWAIT) |-> !scl_oe_o);

  a_r5_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HWAIT && scl_s) |=> (cnt == $past(reload_i) && st_q == ST_HCNT));

  a_r3_low_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LOW) |-> scl_oe_o);

  a_r9_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && buf_wr_i) |=> ($stable(buf_o) && wcol_o));

  a_r10_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wcol_o && !wcol_clr_i) |=> wcol_o);

  a_r11_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (cnt == '0));
endmodule

bind i2c_scl_gen i2c_scl_gen_chk #(.W(RELOAD_W), .DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .st_q      (st_q),
  .cnt       (cnt),
  .scl_s     (scl_s),
  .reload_i  (reload_i),
  .buf_wr_i  (buf_wr_i),
  .wcol_clr_i(wcol_clr_i),
  .busy_o    (busy_o),
  .wcol_o    (wcol_o),
  .buf_o     (buf_o),
  .scl_oe_o  (scl_oe_o)
);

// File: tb/test_i2c_scl_gen.sv
`timescale 1ns/1ps
module test_i2c_scl_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] reload;
  logic       start_req, rstart_req, stop_req, tx_req, rx_req;
  logic       buf_wr, wcol_clr, slave_hold;
  logic [7:0] wdata;
  logic       scl_oe, busy, wcol;
  logic [7:0] buf_q;
  logic       scl_line;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;

  assign scl_line = !scl_oe && !slave_hold;

  always #10 clk = ~clk;

  i2c_scl_gen i_i2c_scl_gen (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reload_i    (reload),
    .scl_i       (scl_line),
    .start_req_i (start_req),
    .rstart_req_i(rstart_req),
    .stop_req_i  (stop_req),
    .tx_req_i    (tx_req),
    .rx_req_i    (rx_req),
    .buf_wr_i    (buf_wr),
    .buf_wdata_i (wdata),
    .wcol_clr_i  (wcol_clr),
    .scl_oe_o    (scl_oe),
    .busy_o      (busy),
    .wcol_o      (wcol),
    .buf_o       (buf_q)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: a prediction of every register after the next edge
  int m_ph, m_s1, m_s2, m_mode, m_cnt, m_left, m_endlow, m_oe, m_buf, m_wcol;

  task automatic model_reset();
    m_ph = 0; m_s1 = 1; m_s2 = 1; m_mode = 0; m_cnt = 0; m_left = 0;
    m_endlow = 0; m_oe = 0; m_buf = 0; m_wcol = 0;
  endtask

  task automatic model_step();
    int was_busy, new_mode, new_cnt, new_left, new_end, new_oe;
    if (!rst_n) begin
      model_reset();
      return;
    end
    was_busy = (m_mode != 0);
    new_mode = m_mode; new_cnt = m_cnt; new_left = m_left;
    new_end = m_endlow; new_oe = m_oe;
    if (m_mode == 0) begin
      if (start_req) begin
        new_mode = 2; new_oe = 0; new_left = 0; new_end = 1;
      end else if (rstart_req || stop_req || tx_req || rx_req) begin
        new_mode = 1; new_oe = 1; new_cnt = reload;
        new_end  = stop_req && !rstart_req ? 0 : 1;
        new_left = (rstart_req || stop_req) ? 1 : 17;
      end
    end else if (m_mode == 2) begin
      if (m_s2 == 1) begin
        new_mode = 3; new_cnt = reload;
      end
    end else begin
      if (m_cnt == 0) begin
        if (m_left == 0) begin
          new_mode = 0; new_oe = m_endlow;
        end else begin
          new_left = m_left - 1;
          if (m_mode == 1) begin
            new_mode = 2; new_oe = 0;
          end else begin
            new_mode = 1; new_oe = 1; new_cnt = reload;
          end
        end
      end else if (m_ph % 2 == 1) begin
        new_cnt = m_cnt - 1;
      end
    end
    if (buf_wr && was_busy)  m_wcol = 1;
    else if (wcol_clr)       m_wcol = 0;
    if (buf_wr && !was_busy) m_buf = wdata;
    m_mode = new_mode; m_cnt = new_cnt; m_left = new_left;
    m_endlow = new_end; m_oe = new_oe;
    m_s2 = m_s1; m_s1 = scl_line;
    m_ph = (m_ph + 1) % 4;
  endtask

  always @(negedge clk) begin
    check(scl_oe === m_oe[0],        "R6 scl_oe vs model", scl_oe, m_oe);
    check(busy === (m_mode != 0),    "R11 busy vs model", busy, m_mode != 0);
    check(wcol === m_wcol[0],        "R10 wcol vs model", wcol, m_wcol);
    check(buf_q === m_buf[7:0],      "R9 buf vs model", buf_q, m_buf);
    model_step();
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic pulse(input int which);
    @(posedge clk); #1;
    case (which)
      0: start_req = 1;
      1: rstart_req = 1;
      2: stop_req = 1;
      3: tx_req = 1;
      default: rx_req = 1;
    endcase
    @(posedge clk); #1;
    start_req = 0; rstart_req = 0; stop_req = 0; tx_req = 0; rx_req = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (!busy) return;
    end
  endtask

  int n;

  initial begin
    model_reset();
    rst_n = 0; reload = 8'd4; slave_hold = 0;
    start_req = 0; rstart_req = 0; stop_req = 0; tx_req = 0; rx_req = 0;
    buf_wr = 0; wcol_clr = 0; wdata = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(!scl_oe, "R1 scl_oe after reset", scl_oe, 0);
    check(!busy,   "R1 busy after reset", busy, 0);
    check(!wcol,   "R1 wcol after reset", wcol, 0);
    check(buf_q == 0, "R1 buf after reset", buf_q, 0);

    // R9 idle write
    @(posedge clk); #1 buf_wr = 1; wdata = 8'hA5;
    @(posedge clk); #1 buf_wr = 0;
    @(negedge clk);
    check(buf_q == 8'hA5, "R9 idle write loads", buf_q, 8'hA5);

    // R6 start ends driven low
    pulse(0);
    @(negedge clk);
    check(busy && !scl_oe, "R6 start begins released", scl_oe, 0);
    wait_idle();
    check(scl_oe, "R6 start leaves SCL low", scl_oe, 1);

    // R2/R3 low half-period length, reload 3
    reload = 8'd3;
    pulse(3);
    while (scl_oe) @(negedge clk);
    while (!scl_oe) @(negedge clk);
    n = 0;
    while (scl_oe) begin n++; @(negedge clk); end
    check(n == 6 || n == 7, "R2 low half-period clocks", n, 6);
    // R9 collision while busy
    @(posedge clk); #1 buf_wr = 1; wdata = 8'h5A;
    @(posedge clk); #1 buf_wr = 0;
    @(negedge clk);
    check(buf_q == 8'hA5, "R9 busy write refused", buf_q, 8'hA5);
    check(wcol, "R9 busy write sets wcol", wcol, 1);
    // R8 stop while busy ignored
    pulse(2);
    wait_idle();
    repeat (10) @(negedge clk);
    check(!busy && scl_oe, "R8 stop during transfer dropped", scl_oe, 1);

    // R10 clear, then clear with collision
    @(posedge clk); #1 wcol_clr = 1;
    @(posedge clk); #1 wcol_clr = 0;
    @(negedge clk);
    check(!wcol, "R10 clear strobe", wcol, 0);
    pulse(0);
    @(posedge clk); #1 wcol_clr = 1; buf_wr = 1; wdata = 8'h11;
    @(posedge clk); #1 wcol_clr = 0; buf_wr = 0;
    @(negedge clk);
    check(wcol, "R10 set wins over clear", wcol, 1);
    wait_idle();
    @(posedge clk); #1 wcol_clr = 1;
    @(posedge clk); #1 wcol_clr = 0;

    // R4/R5 stretch during stop
    reload = 8'd5;
    @(posedge clk); #1 slave_hold = 1;
    pulse(2);
    repeat (100) @(negedge clk);
    check(busy && !scl_oe, "R4 held line freezes sequence", busy, 1);
    @(posedge clk); #1 slave_hold = 0;
    n = 0;
    for (int i = 0; i < 200 && busy; i++) begin
      @(negedge clk);
      if (scl_line) n++;
    end
    check(n >= 10, "R5 high time after stretch", n, 10);
    check(!busy && !scl_oe, "R6 stop leaves SCL released", scl_oe, 0);

    // R7 start and stop together from idle
    @(posedge clk); #1 start_req = 1; stop_req = 1;
    @(posedge clk); #1 start_req = 0; stop_req = 0;
    @(negedge clk);
    check(busy && !scl_oe, "R7 start wins over stop", scl_oe, 0);
    wait_idle();
    check(scl_oe, "R7 start outcome left SCL low", scl_oe, 1);

    // R3 boundary reload 0 with receive
    reload = 8'd0;
    pulse(4);
    wait_idle();
    check(!busy && scl_oe, "R3 reload zero receive completes", busy, 0);

    // R6 repeated start
    reload = 8'd2;
    pulse(1);
    @(negedge clk);
    check(busy && scl_oe, "R6 repeated start begins low", scl_oe, 1);
    wait_idle();
    check(scl_oe, "R6 repeated start leaves SCL low", scl_oe, 1);

    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule